// File: doc/BRIEF.md
# Floating-Point Register Load/Store Unit

This block carries out one floating-point register load or store at a time. An instruction arrives as a group select, a 4-bit sub-opcode and the usual register and immediate fields. The block looks up the base and index general registers and works out the effective address in one of two ways. The register-indexed group adds two general registers. The immediate group adds an unsigned 8-bit offset, scaled by four, to the base register. Before any memory traffic, the block checks that the coprocessor and floating-point options are enabled, that the sub-opcode is defined, and that the address is word aligned.

When every check passes, the block raises a 32-bit word request on a simple request/acknowledge memory port. It holds the request until the acknowledge arrives. It then spends one completion cycle in which it writes the loaded word into the floating-point register file and, if the instruction asks for it, writes the effective address back into the base register. An instruction that fails a check skips memory entirely. It completes one cycle after it is accepted and reports an exception code.

Top module: `fpls_unit`

## Requirements
- R1: With `op_grp`=0 (indexed group), sub-opcode 0 is a load, 1 a load with update, 4 a store and 5 a store with update. Every other value gives exception code 2 (reserved). The data register is `op_r`.
- R2: With `op_grp`=1 (immediate group), sub-opcode 0 is a load, 4 a store, 8 a load with update and 12 a store with update. Every other value gives exception code 2. The data register is `op_t`.
- R3: In the indexed group the effective address is gr[`op_s`] + gr[`op_t`], modulo 2^32.
- R4: In the immediate group the effective address is gr[`op_s`] + (`op_imm8` zero-extended × 4), modulo 2^32.
- R5: An effective address with either of bits 1:0 set gives exception code 3 (misaligned). It issues no memory request and writes neither register file.
- R6: If `cfg_cp_en` or `cfg_fp_en` is 0, the instruction gives exception code 1 (illegal). This takes priority over codes 2 and 3. No memory request is issued and nothing is written.
- R7: A reserved sub-opcode (code 2) takes priority over misalignment (code 3). It issues no memory request and writes nothing.
- R8: A load writes the acknowledged memory word, unchanged in all 32 bits, into fr[data register]. The write port is valid in the completion cycle.
- R9: A store issues exactly one write request whose data is fr[data register] and whose address is the effective address. A load issues exactly one read request.
- R10: An instruction with update writes the effective address into gr[`op_s`] in the completion cycle. An instruction without update, or one that raises an exception, does not write the general register file.
- R11: `op_ready` is high only while idle. `op_done` is a one-cycle pulse. It comes one cycle after the accepting edge for an exception, and one cycle after the acknowledging edge for a memory access.
- R12: Once raised, `mem_req` stays high, with address, direction and data unchanged, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction offered |
| op_ready | output | 1 | Unit idle and accepting |
| op_grp | input | 1 | 0 = indexed group, 1 = immediate group |
| op_sub | input | 4 | Sub-opcode field |
| op_s | input | 4 | Base general register |
| op_t | input | 4 | Index general register (indexed) / data FP register (immediate) |
| op_r | input | 4 | Data FP register (indexed) |
| op_imm8 | input | 8 | Unsigned offset in words (immediate group) |
| cfg_cp_en | input | 1 | Coprocessor option enabled |
| cfg_fp_en | input | 1 | Floating-point option enabled |
| gr_rd_a_idx | output | 4 | General register read index (base) |
| gr_rd_a_data | input | 32 | Base register value |
| gr_rd_b_idx | output | 4 | General register read index (index) |
| gr_rd_b_data | input | 32 | Index register value |
| fr_rd_idx | output | 4 | FP register read index (store data) |
| fr_rd_data | input | 32 | FP register value |
| gr_we | output | 1 | General register write enable (post-update) |
| gr_widx | output | 4 | General register write index |
| gr_wdata | output | 32 | General register write data |
| fr_we | output | 1 | FP register write enable (load) |
| fr_widx | output | 4 | FP register write index |
| fr_wdata | output | 32 | FP register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| op_done | output | 1 | Instruction complete |
| exc_valid | output | 1 | Completion carries an exception |
| exc_code | output | 2 | 0 none, 1 illegal, 2 reserved, 3 misaligned |

## Verification
Each instruction is offered on a falling edge and is accepted on the next rising edge. The bench then counts falling edges. A faulting instruction must show `op_done` on the first one. A memory instruction whose acknowledge the bench delays by L cycles must show it on falling edge L+2. All results are sampled on that falling edge: the exception code, both register-file write ports, and the counts of requests and stores the memory model saw. The sweep covers every sub-opcode of both groups, aligned and misaligned, with acknowledge delays of 0 to 2 cycles, plus every disabled-option combination.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

  localparam int SUBW = 4;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_ILLEGAL  = 2'd1,
    EXC_RESERVED = 2'd2,
    EXC_ALIGN    = 2'd3
  } exc_e;

  typedef struct packed {
    logic defined;
    logic store;
    logic update;
  } opkind_t;

  // Sub-opcode split: bit 2 is direction in both groups; update is bit 0
  // (indexed) or bit 3 (immediate); the remaining bits must be zero.
  function automatic opkind_t classify(input logic grp, input logic [SUBW-1:0] sub);
    opkind_t k;
    k.store = sub[2];
    if (!grp) begin
      k.defined = (sub[3] == 1'b0) && (sub[1] == 1'b0);
      k.update  = sub[0];
    end else begin
      k.defined = (sub[1:0] == 2'b00);
      k.update  = sub[3];
    end
    return k;
  endfunction

endpackage

// File: rtl/fpls_decode.sv
module fpls_decode
  import fpls_pkg::*;
#(
  parameter int RIW = 4
) (
  input  logic            grp,
  input  logic [SUBW-1:0] sub,
  input  logic            cp_en,
  input  logic            fp_en,
  input  logic [RIW-1:0]  t_idx,
  input  logic [RIW-1:0]  r_idx,
  output logic            is_store,
  output logic            is_update,
  output exc_e            pre_exc,
  output logic [RIW-1:0]  data_idx
);

  opkind_t kind;

  always_comb begin
    kind      = classify(grp, sub);
    is_store  = kind.store;
    is_update = kind.update;
    data_idx  = grp ? t_idx : r_idx;
    if (!(cp_en && fp_en))  pre_exc = EXC_ILLEGAL;
    else if (!kind.defined) pre_exc = EXC_RESERVED;
    else                    pre_exc = EXC_NONE;
  end

endmodule

// File: rtl/fpls_agu.sv
module fpls_agu #(
  parameter int XLEN  = 32,
  parameter int IMMW  = 8,
  parameter int SCALE = 2
) (
  input  logic            grp,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] ea,
  output logic            misaligned
);

  localparam int ALW = SCALE;

  function automatic logic [XLEN-1:0] scaled_off(input logic [IMMW-1:0] v);
    return XLEN'(v) << SCALE;
  endfunction

  function automatic logic [XLEN-1:0] eff_addr(input logic g,
                                               input logic [XLEN-1:0] b,
                                               input logic [XLEN-1:0] x,
                                               input logic [IMMW-1:0] i);
    return b + (g ? scaled_off(i) : x);
  endfunction

  always_comb begin
    ea         = eff_addr(grp, base, index, imm);
    misaligned = (ea[ALW-1:0] != '0);
  end

endmodule

// File: rtl/fpls_seq.sv
module fpls_seq
  import fpls_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  exc_e            pre_exc,
  input  logic            misaligned,
  input  logic [XLEN-1:0] ea,
  input  logic            is_store,
  input  logic            is_update,
  input  logic [RIW-1:0]  data_idx,
  input  logic [RIW-1:0]  base_idx,
  input  logic [XLEN-1:0] st_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            gr_we,
  output logic [RIW-1:0]  gr_widx,
  output logic [XLEN-1:0] gr_wdata,
  output logic            fr_we,
  output logic [RIW-1:0]  fr_widx,
  output logic [XLEN-1:0] fr_wdata,
  output logic            op_done,
  output logic            exc_valid,
  output logic [1:0]      exc_code
);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DONE} state_e;

  state_e          state_q;
  exc_e            exc_q;
  logic            st_q, upd_q;
  logic [XLEN-1:0] addr_q, wdata_q, rdata_q;
  logic [RIW-1:0]  didx_q, bidx_q;

  // named events
  logic accept, mem_fire, clean;
  exc_e fault;

  assign accept   = op_valid && (state_q == S_IDLE);
  assign mem_fire = mem_req && mem_ack;
  assign fault    = (pre_exc != EXC_NONE) ? pre_exc :
                    (misaligned ? EXC_ALIGN : EXC_NONE);
  assign clean    = (exc_q == EXC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      exc_q   <= EXC_NONE;
      st_q    <= 1'b0;
      upd_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      didx_q  <= '0;
      bidx_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          exc_q   <= fault;
          st_q    <= is_store;
          upd_q   <= is_update;
          addr_q  <= ea;
          wdata_q <= st_data;
          didx_q  <= data_idx;
          bidx_q  <= base_idx;
          state_q <= (fault == EXC_NONE) ? S_MEM : S_DONE;
        end
        S_MEM: if (mem_ack) begin
          rdata_q <= mem_rdata;
          state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign op_ready  = (state_q == S_IDLE);
  assign mem_req   = (state_q == S_MEM);
  assign mem_we    = st_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign op_done   = (state_q == S_DONE);
  assign exc_valid = op_done && !clean;
  assign exc_code  = op_done ? exc_q : EXC_NONE;
  assign fr_we     = op_done && clean && !st_q;
  assign fr_widx   = didx_q;
  assign fr_wdata  = rdata_q;
  assign gr_we     = op_done && clean && upd_q;
  assign gr_widx   = bidx_q;
  assign gr_wdata  = addr_q;

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!mem_req && !op_done));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> (op_done && !exc_valid));

  p_fault_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fault != EXC_NONE) |=> (!mem_req && op_done && exc_valid));

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  p_aligned_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_update_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we || fr_we) |-> (op_done && !exc_valid));

endmodule

// File: rtl/fpls_unit.sv
module fpls_unit
  import fpls_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RIW   = 4,
  parameter int IMMW  = 8,
  parameter int SCALE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic            op_grp,
  input  logic [3:0]      op_sub,
  input  logic [RIW-1:0]  op_s,
  input  logic [RIW-1:0]  op_t,
  input  logic [RIW-1:0]  op_r,
  input  logic [IMMW-1:0] op_imm8,
  input  logic            cfg_cp_en,
  input  logic            cfg_fp_en,
  output logic [RIW-1:0]  gr_rd_a_idx,
  input  logic [XLEN-1:0] gr_rd_a_data,
  output logic [RIW-1:0]  gr_rd_b_idx,
  input  logic [XLEN-1:0] gr_rd_b_data,
  output logic [RIW-1:0]  fr_rd_idx,
  input  logic [XLEN-1:0] fr_rd_data,
  output logic            gr_we,
  output logic [RIW-1:0]  gr_widx,
  output logic [XLEN-1:0] gr_wdata,
  output logic            fr_we,
  output logic [RIW-1:0]  fr_widx,
  output logic [XLEN-1:0] fr_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            op_done,
  output logic            exc_valid,
  output logic [1:0]      exc_code
);

  logic            is_store, is_update, misaligned;
  exc_e            pre_exc;
  logic [RIW-1:0]  data_idx;
  logic [XLEN-1:0] ea;

  assign gr_rd_a_idx = op_s;
  assign gr_rd_b_idx = op_t;
  assign fr_rd_idx   = data_idx;

  fpls_decode #(.RIW(RIW)) u_dec (
    .grp       (op_grp),
    .sub       (op_sub),
    .cp_en     (cfg_cp_en),
    .fp_en     (cfg_fp_en),
    .t_idx     (op_t),
    .r_idx     (op_r),
    .is_store  (is_store),
    .is_update (is_update),
    .pre_exc   (pre_exc),
    .data_idx  (data_idx)
  );

  fpls_agu #(.XLEN(XLEN), .IMMW(IMMW), .SCALE(SCALE)) u_agu (
    .grp        (op_grp),
    .base       (gr_rd_a_data),
    .index      (gr_rd_b_data),
    .imm        (op_imm8),
    .ea         (ea),
    .misaligned (misaligned)
  );

  fpls_seq #(.XLEN(XLEN), .RIW(RIW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .pre_exc    (pre_exc),
    .misaligned (misaligned),
    .ea         (ea),
    .is_store   (is_store),
    .is_update  (is_update),
    .data_idx   (data_idx),
    .base_idx   (op_s),
    .st_data    (fr_rd_data),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .gr_we      (gr_we),
    .gr_widx    (gr_widx),
    .gr_wdata   (gr_wdata),
    .fr_we      (fr_we),
    .fr_widx    (fr_widx),
    .fr_wdata   (fr_wdata),
    .op_done    (op_done),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code)
  );

endmodule

// File: tb/fpls_unit_tb.sv
`timescale 1ns/1ps
module fpls_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_ready;
  logic        op_grp = 1'b0;
  logic [3:0]  op_sub = '0, op_s = '0, op_t = '0, op_r = '0;
  logic [7:0]  op_imm8 = '0;
  logic        cfg_cp_en = 1'b1, cfg_fp_en = 1'b1;
  logic [3:0]  gr_rd_a_idx, gr_rd_b_idx, fr_rd_idx;
  logic [31:0] gr_rd_a_data, gr_rd_b_data, fr_rd_data;
  logic        gr_we, fr_we;
  logic [3:0]  gr_widx, fr_widx;
  logic [31:0] gr_wdata, fr_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        op_done, exc_valid;
  logic [1:0]  exc_code;

  logic [31:0] gr [16];
  logic [31:0] fr [16];
  logic [31:0] mem [64];
  int lat = 0, wait_cnt = 0, req_cnt = 0, st_cnt = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign gr_rd_a_data = gr[gr_rd_a_idx];
  assign gr_rd_b_data = gr[gr_rd_b_idx];
  assign fr_rd_data   = fr[fr_rd_idx];
  assign mem_ack      = mem_req && (wait_cnt >= lat);
  assign mem_rdata    = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h8000_0001 ^ (i * 32'h0103_0507);
      wait_cnt <= 0;
    end else begin
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req && mem_ack && mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        st_cnt <= st_cnt + 1;
      end
    end
  end

  fpls_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit grp, input logic [3:0] sub, input int mis,
                        input bit cp, input bit fp, input int l);
    logic [3:0]  s, t, r, didx;
    logic [31:0] base, idx, ea, fval, mold;
    logic [7:0]  imm;
    bit ok, st, upd;
    logic [1:0] ec;
    int n;
    s = sub; t = sub + 4'd5; r = sub + 4'd10;
    imm  = 8'h05 + 8'(sub);
    base = 32'h40 + 32'(sub) * 8 + 32'(mis);
    idx  = 32'h20 + 32'(sub) * 4;
    gr[s] = base; gr[t] = idx;
    didx = grp ? t : r;
    fval = fr[didx];
    ea   = grp ? base + (32'(imm) * 4) : base + idx;
    ok   = grp ? (sub[1:0] == 2'b00) : (sub == 4'd0 || sub == 4'd1 || sub == 4'd4 || sub == 4'd5);
    st   = sub[2];
    upd  = grp ? sub[3] : sub[0];
    if (!(cp && fp)) ec = 2'd1;
    else if (!ok) ec = 2'd2;
    else if (ea[1:0] != 2'b00) ec = 2'd3;
    else ec = 2'd0;
    mold = mem[ea[7:2]];
    @(negedge clk);
    op_grp = grp; op_sub = sub; op_s = s; op_t = t; op_r = r; op_imm8 = imm;
    cfg_cp_en = cp; cfg_fp_en = fp; lat = l; req_cnt = 0; st_cnt = 0;
    chk(op_ready == 1'b1, "R11 ready when idle", 32'(op_ready), 32'd1);
    op_valid = 1'b1;
    @(posedge clk); #1 op_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!op_done && n < 40);
    chk(n == ((ec != 0) ? 1 : l + 2), "R11 done latency", 32'(n), 32'((ec != 0) ? 1 : l + 2));
    chk(op_ready == 1'b0, "R11 not ready during done", 32'(op_ready), 32'd0);
    chk(exc_code == ec && exc_valid == (ec != 0),
        (ec == 1) ? "R6 option exception" : (ec == 2) ? (grp ? "R2 reserved" : "R1 reserved") :
        (ec == 3) ? "R5 misaligned" : (grp ? "R2 decode" : "R1 decode"),
        32'(exc_code), 32'(ec));
    if (ec != 0) begin
      chk(req_cnt == 0 && !gr_we && !fr_we, (ec == 2) ? "R7 no side effect" : "R5 R6 no side effect",
          32'(req_cnt), 32'd0);
    end else begin
      chk(req_cnt == l + 1, "R12 request held until ack", 32'(req_cnt), 32'(l + 1));
      chk(st_cnt == (st ? 1 : 0), "R9 single store", 32'(st_cnt), 32'(st ? 1 : 0));
      if (st) chk(mem[ea[7:2]] == fval, grp ? "R9 R4 store data/addr" : "R9 R3 store data/addr",
                  mem[ea[7:2]], fval);
      else chk(fr_we && fr_widx == didx && fr_wdata == mold,
               grp ? "R8 R4 load value" : "R8 R3 load value", fr_wdata, mold);
      chk(gr_we == upd, "R10 update enable", 32'(gr_we), 32'(upd));
      if (upd) chk(gr_widx == s && gr_wdata == ea, "R10 update value", gr_wdata, ea);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      gr[i] = 32'h0;
      fr[i] = 32'hC0DE_0000 + i * 32'h111;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(op_ready == 1'b1 && !mem_req && !op_done && !gr_we && !fr_we, "R11 reset state",
        {mem_req, op_done, gr_we, fr_we}, 32'd0);
    #1 rst_n = 1'b1;
    for (int g = 0; g < 2; g++)
      for (int sb = 0; sb < 16; sb++)
        for (int m = 0; m < 2; m++)
          run_op(g[0], 4'(sb), m * (1 + sb % 3), 1'b1, 1'b1, (sb + m) % 3);
    for (int c = 0; c < 3; c++) begin
      run_op(1'b0, 4'd4, 0, c[0], c[1], 0);
      run_op(1'b1, 4'd3, 2, c[0], c[1], 0);
      run_op(1'b0, 4'd2, 1, 1'b1, 1'b1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule